// File: doc/BRIEF.md
# Stationary-Frame Current and Voltage Transform

This block takes one sample of two stator phase currents, the DC-link voltage and the three inverter leg switch states. It produces the two-axis stationary-frame (alpha/beta) current and voltage for a motor control estimator. The voltages are not measured. They are rebuilt from the switch states and the DC-link level. All arithmetic is signed two's-complement fixed point. Every scaling is a multiplication by a fixed constant, followed by a fixed bit-slice truncation.

A sample enters on a valid/ready input handshake. The four results leave together on a valid/ready output handshake behind a single register stage. The input is accepted when the output register is empty or is being drained in the same cycle, so `s_ready = !m_valid || m_ready`. While the output holds a result that the consumer has not taken, the result and its valid flag stay frozen, and new input is refused. A producer that ignores `s_ready` loses its sample.

Top module: `stat_frame_xform`

## Requirements
- R1: `i_alpha` is phase A current (17-bit signed, 12 fraction bits) sign-extended to 18 bits, with the same 12 fraction bits.
- R2: `i_beta` is bits [35:18] of the 38-bit signed product (A + 2·B) × 151349. The sum A + 2·B is formed in 19 signed bits. The constant is 1/√3 with 18 fraction bits. The result is floor-rounded, with 12 fraction bits.
- R3: `v_alpha` is bits [27:6] of the 34-bit signed product (Vdc × (2·Sa − Sb − Sc)) × 87381. Vdc is 12-bit unsigned. The constant is 1/3 with 18 fraction bits. Higher product bits are discarded, so large magnitudes wrap modulo 2^22.
- R4: `v_beta` is bits [27:6] of the 34-bit signed product (Vdc × (Sb − Sc)) × 151349, with the same truncation as R3.
- R5: When all three switch bits are equal (all 0 or all 1), both voltage outputs are zero for any Vdc.
- R6: A sample accepted at a clock edge (`s_valid && s_ready`) appears on the outputs with `m_valid` high right after that edge.
- R7: While `m_valid` is high and `m_ready` is low, `m_valid` and all four result outputs hold their values.
- R8: `s_ready` is high exactly when `m_valid` is low or `m_ready` is high. A sample offered while `s_ready` is low is dropped and never reaches the outputs.
- R9: After reset, `m_valid` is low, `s_ready` is high and all result outputs are zero.
- R10: When the output is taken (`m_valid && m_ready`) and no new sample is accepted at that edge, `m_valid` is low after the edge. Each accepted sample yields exactly one output beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample can be accepted |
| phase_a | input | 17 | Phase A current, signed, 12 fraction bits |
| phase_b | input | 17 | Phase B current, signed, 12 fraction bits |
| vdc | input | 12 | DC-link voltage, unsigned |
| sw_a | input | 1 | Leg A switch state (1 = upper device on) |
| sw_b | input | 1 | Leg B switch state |
| sw_c | input | 1 | Leg C switch state |
| m_valid | output | 1 | Result valid |
| m_ready | input | 1 | Consumer takes the result |
| i_alpha | output | 18 | Alpha current, signed, 12 fraction bits |
| i_beta | output | 18 | Beta current, signed, 12 fraction bits |
| v_alpha | output | 22 | Alpha voltage, signed, 12 fraction bits |
| v_beta | output | 22 | Beta voltage, signed, 12 fraction bits |

## Verification
Random currents over the full 17-bit signed range exercise the sign handling of the 19-bit sum and the floor truncation of negative products. Random DC-link levels with all eight switch patterns separate the 1/3 and 1/√3 legs and the sign of each coefficient. Directed corners cover the extreme currents, full-scale Vdc (which shows the wrap of the discarded upper product bits) and equal switch states (zero voltage). A back-pressure sequence holds the consumer off while a second sample is offered, to show that the result stays frozen and that the refused sample never appears.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
  // Fixed-point constants with 18 fraction bits in a 19-bit signed word.
  localparam int unsigned K_W = 19;
  localparam logic signed [K_W-1:0] K_INV_SQRT3 = 19'sh24F35; // 151349
  localparam logic signed [K_W-1:0] K_THIRD     = 19'sh15555; // 87381

  // Switch-pattern coefficient width: values -2..2.
  localparam int unsigned COEF_W = 3;
endpackage

// File: rtl/sfx_current.sv
module sfx_current #(
  parameter int unsigned CUR_W  = 17,
  parameter int unsigned K_W    = 19,
  parameter logic signed [K_W-1:0] K_SCALE = 19'sh24F35
) (
  input  logic signed [CUR_W-1:0] ph_a,
  input  logic signed [CUR_W-1:0] ph_b,
  output logic signed [CUR_W:0]   alpha,
  output logic signed [CUR_W:0]   beta
);
  localparam int unsigned SUM_W  = CUR_W + 2;
  localparam int unsigned PROD_W = SUM_W + K_W;
  localparam int unsigned OUT_W  = CUR_W + 1;
  localparam int unsigned K_FRAC = K_W - 1;
  localparam int unsigned HI     = K_FRAC + OUT_W - 1;

  logic signed [SUM_W-1:0]  a_ext;
  logic signed [SUM_W-1:0]  b_dbl;
  logic signed [SUM_W-1:0]  sum;
  logic signed [PROD_W-1:0] prod;

  // Widen both terms before adding so the sum cannot overflow.
  assign a_ext = {{(SUM_W-CUR_W){ph_a[CUR_W-1]}}, ph_a};
  assign b_dbl = {ph_b[CUR_W-1], ph_b, 1'b0};
  assign sum   = a_ext + b_dbl;
  assign prod  = sum * K_SCALE;

  assign alpha = {ph_a[CUR_W-1], ph_a};
  assign beta  = prod[HI:K_FRAC];

  logic unused_prod_bits;
  assign unused_prod_bits = ^{prod[PROD_W-1:HI+1], prod[K_FRAC-1:0]};
endmodule

// File: rtl/sfx_voltage_leg.sv
module sfx_voltage_leg #(
  parameter int unsigned VDC_W  = 12,
  parameter int unsigned COEF_W = 3,
  parameter int unsigned K_W    = 19,
  parameter logic signed [K_W-1:0] K_SCALE = 19'sh15555,
  parameter int unsigned OUT_W  = 22,
  parameter int unsigned LSB    = 6
) (
  input  logic [VDC_W-1:0]         vdc,
  input  logic signed [COEF_W-1:0] coef,
  output logic signed [OUT_W-1:0]  volt
);
  localparam int unsigned MUL_W  = VDC_W + COEF_W;
  localparam int unsigned PROD_W = MUL_W + K_W;
  localparam int unsigned HI     = LSB + OUT_W - 1;

  logic signed [MUL_W-1:0]  vdc_s;
  logic signed [MUL_W-1:0]  coef_s;
  logic signed [MUL_W-1:0]  scaled;
  logic signed [PROD_W-1:0] prod;

  assign vdc_s  = {{COEF_W{1'b0}}, vdc};
  assign coef_s = {{VDC_W{coef[COEF_W-1]}}, coef};
  assign scaled = vdc_s * coef_s;
  assign prod   = scaled * K_SCALE;
  assign volt   = prod[HI:LSB];

  logic unused_prod_bits;
  assign unused_prod_bits = ^{prod[PROD_W-1:HI+1], prod[LSB-1:0]};
endmodule

// File: rtl/sfx_out_stage.sv
module sfx_out_stage #(
  parameter int unsigned W = 80
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  p_beat_after_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid && out_data == $past(in_data));

  p_hold_stalled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_single_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);
endmodule

// File: rtl/stat_frame_xform.sv
module stat_frame_xform #(
  parameter int unsigned CUR_W   = 17,
  parameter int unsigned VDC_W   = 12,
  parameter int unsigned VOUT_W  = 22,
  parameter int unsigned V_LSB   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s_valid,
  output logic                     s_ready,
  input  logic signed [CUR_W-1:0]  phase_a,
  input  logic signed [CUR_W-1:0]  phase_b,
  input  logic [VDC_W-1:0]         vdc,
  input  logic                     sw_a,
  input  logic                     sw_b,
  input  logic                     sw_c,
  output logic                     m_valid,
  input  logic                     m_ready,
  output logic signed [CUR_W:0]    i_alpha,
  output logic signed [CUR_W:0]    i_beta,
  output logic signed [VOUT_W-1:0] v_alpha,
  output logic signed [VOUT_W-1:0] v_beta
);
  import sfx_pkg::*;

  localparam int unsigned IOUT_W = CUR_W + 1;
  localparam int unsigned DATA_W = 2*IOUT_W + 2*VOUT_W;
  localparam int unsigned N_LEG  = 2;

  logic signed [IOUT_W-1:0] ia_c, ib_c;
  logic signed [VOUT_W-1:0] volt_c [N_LEG];
  logic signed [COEF_W-1:0] coef   [N_LEG];
  logic [DATA_W-1:0]        pack_in, pack_out;

  sfx_current #(
    .CUR_W(CUR_W), .K_W(K_W), .K_SCALE(K_INV_SQRT3)
  ) u_cur (
    .ph_a(phase_a), .ph_b(phase_b), .alpha(ia_c), .beta(ib_c)
  );

  // Leg 0: alpha axis, 1/3 scale, coefficient 2Sa - Sb - Sc.
  // Leg 1: beta axis, 1/sqrt(3) scale, coefficient Sb - Sc.
  assign coef[0] = $signed({1'b0, sw_a, 1'b0}) - $signed({2'b00, sw_b})
                 - $signed({2'b00, sw_c});
  assign coef[1] = $signed({2'b00, sw_b}) - $signed({2'b00, sw_c});

  for (genvar g = 0; g < N_LEG; g++) begin : g_leg
    localparam logic signed [K_W-1:0] K_LEG = (g == 0) ? K_THIRD : K_INV_SQRT3;
    sfx_voltage_leg #(
      .VDC_W(VDC_W), .COEF_W(COEF_W), .K_W(K_W), .K_SCALE(K_LEG),
      .OUT_W(VOUT_W), .LSB(V_LSB)
    ) u_leg (
      .vdc(vdc), .coef(coef[g]), .volt(volt_c[g])
    );
  end

  assign pack_in = {ia_c, ib_c, volt_c[0], volt_c[1]};

  sfx_out_stage #(.W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(s_valid), .in_ready(s_ready), .in_data(pack_in),
    .out_valid(m_valid), .out_ready(m_ready), .out_data(pack_out)
  );

  assign {i_alpha, i_beta, v_alpha, v_beta} = pack_out;

  p_equal_switch_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && sw_a == sw_b && sw_b == sw_c
    |=> v_alpha == '0 && v_beta == '0);

  p_alpha_tracks_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> i_alpha == IOUT_W'($past(phase_a)));
endmodule

// File: tb/stat_frame_xform_test.sv
module stat_frame_xform_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic signed [16:0] phase_a = '0, phase_b = '0;
  logic [11:0] vdc = '0;
  logic sw_a = 0, sw_b = 0, sw_c = 0;
  logic m_valid;
  logic m_ready = 1'b1;
  logic signed [17:0] i_alpha, i_beta;
  logic signed [21:0] v_alpha, v_beta;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  stat_frame_xform uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .phase_a(phase_a), .phase_b(phase_b), .vdc(vdc),
    .sw_a(sw_a), .sw_b(sw_b), .sw_c(sw_c),
    .m_valid(m_valid), .m_ready(m_ready),
    .i_alpha(i_alpha), .i_beta(i_beta), .v_alpha(v_alpha), .v_beta(v_beta)
  );

  function automatic longint exp_ibeta(longint a, longint b);
    longint p;
    logic signed [17:0] r;
    p = (a + 2*b) * 151349;
    r = p[35:18];
    return longint'(r);
  endfunction

  function automatic longint exp_volt(longint v, longint m, longint k);
    longint p;
    logic signed [21:0] r;
    p = v * m * k;
    r = p[27:6];
    return longint'(r);
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_outputs(logic signed [16:0] a, logic signed [16:0] b,
                               logic [11:0] v, logic sa, logic sb, logic sc);
    longint ma, mb;
    ma = 2*longint'(sa) - longint'(sb) - longint'(sc);
    mb = longint'(sb) - longint'(sc);
    chk("R6 m_valid", longint'(m_valid), 1);
    chk("R1 i_alpha", longint'(i_alpha), longint'(a));
    chk("R2 i_beta", longint'(i_beta), exp_ibeta(longint'(a), longint'(b)));
    chk("R3 v_alpha", longint'(v_alpha), exp_volt(longint'(v), ma, 87381));
    chk("R4 v_beta", longint'(v_beta), exp_volt(longint'(v), mb, 151349));
    if (sa == sb && sb == sc) begin
      chk("R5 v_alpha zero", longint'(v_alpha), 0);
      chk("R5 v_beta zero", longint'(v_beta), 0);
    end
  endtask

  task automatic send(logic signed [16:0] a, logic signed [16:0] b,
                      logic [11:0] v, logic sa, logic sb, logic sc);
    phase_a = a; phase_b = b; vdc = v; sw_a = sa; sw_b = sb; sw_c = sc;
    s_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    check_outputs(a, b, v, sa, sb, sc);
    @(negedge clk);
    chk("R10 single beat", longint'(m_valid), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R9: reset state
    chk("R9 m_valid", longint'(m_valid), 0);
    chk("R9 s_ready", longint'(s_ready), 1);
    chk("R9 i_alpha", longint'(i_alpha), 0);
    chk("R9 v_beta", longint'(v_beta), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners
    send(17'sh0FFFF, 17'sh0FFFF, 12'd0, 1, 0, 0);
    send(-17'sh10000, -17'sh10000, 12'd100, 0, 1, 0);
    send(17'sd0, 17'sd0, 12'hFFF, 1, 0, 0);     // wrap of discarded upper bits
    send(17'sd4096, -17'sd1, 12'hFFF, 1, 1, 1); // R5 all on
    send(-17'sd3, 17'sd5, 12'd777, 0, 0, 0);    // R5 all off
    send(17'sd1, 17'sd0, 12'd300, 0, 0, 1);

    // Random sweep
    for (int n = 0; n < 400; n++) begin
      logic [2:0] sw;
      sw = 3'($urandom);
      send(17'($urandom), 17'($urandom), 12'($urandom), sw[2], sw[1], sw[0]);
    end

    // R7/R8: back-pressure, refused sample is dropped
    m_ready = 1'b0;
    send_stalled();
    m_ready = 1'b1;
    @(negedge clk);
    chk("R8 stalled sample dropped", longint'(m_valid), 0);
    chk("R8 ready after drain", longint'(s_ready), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic send_stalled();
    phase_a = 17'sd1234; phase_b = -17'sd987; vdc = 12'd500;
    sw_a = 1; sw_b = 0; sw_c = 1;
    s_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_outputs(17'sd1234, -17'sd987, 12'd500, 1, 0, 1);
    // Offer a different sample while the output is stalled.
    phase_a = 17'sd7; phase_b = 17'sd7; vdc = 12'd9; sw_a = 0; sw_b = 1; sw_c = 0;
    for (int k = 0; k < 3; k++) begin
      chk("R8 s_ready low", longint'(s_ready), 0);
      @(negedge clk);
      chk("R7 hold valid", longint'(m_valid), 1);
      chk("R7 hold i_alpha", longint'(i_alpha), 1234);
      chk("R7 hold v_alpha", longint'(v_alpha), exp_volt(500, 1, 87381));
    end
    s_valid = 1'b0;
  endtask
endmodule